// File: doc/BRIEF.md
# CAN Overload Frame Trigger

This block decides when a CAN node has to begin an overload frame. The protocol engine feeds it a bit-sample strobe with the sampled bus level. With each strobe it also gives the position of that bit: an intermission bit index, a last-bit-of-end-of-frame flag or a last-bit-of-delimiter flag. The node's current role comes in as well. From these the block raises reactive overload requests. When a configuration bit allows it, the block also raises a request overload once after every message written into a receive mailbox.

The output is a single-clock start pulse with a two-bit cause code. Both are registered, so the pulse appears on the clock after the strobe that caused it. A request overload that the mailbox side asks for is remembered as pending. It is released at the first bit of the next intermission field. Sending the overload flag itself belongs to the bit engine downstream.

Top module: `ovl_trigger`

## Requirements
- R1: During and right after reset, `ovlStart` is 0, `ovlCause` is 00 and no automatic request is pending.
- R2: A strobe with `rxBit`=0 (dominant) while `imValid`=1 and `imIdx` is 0 or 1 gives `ovlStart`=1 with `ovlCause`=01 on the next clock.
- R3: A dominant strobe at intermission index 2 gives no request.
- R4: A dominant strobe with `eofLast`=1 gives `ovlCause`=10 on the next clock when `isTx`=0 (receiver). It gives no request when `isTx`=1 (transmitter).
- R5: A dominant strobe with `delimLast`=1 gives `ovlCause`=10 on the next clock for either role.
- R6: A strobe with `rxBit`=1 (recessive) never gives a reactive request.
- R7: A `msgStored` pulse while `autoOvlEn`=1 makes an automatic request pending. The next strobe with `imValid`=1 and `imIdx`=0 clears it and, if that bit is recessive, gives `ovlStart`=1 with `ovlCause`=11 on the next clock.
- R8: A dominant bit at intermission index 0 while a request is pending gives cause 01 and still clears the pending request.
- R9: With `autoOvlEn`=0, `msgStored` has no effect. Clearing `autoOvlEn` drops a pending request.
- R10: `ovlStart` is high for one clock per triggering strobe, and `ovlCause` reads 00 whenever `ovlStart` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Bit-sample strobe |
| rxBit | input | 1 | Sampled bus level, 0 = dominant |
| imValid | input | 1 | Current bit lies in the intermission field |
| imIdx | input | 2 | Intermission bit index, 0 to 2 |
| eofLast | input | 1 | Current bit is the last end-of-frame bit |
| delimLast | input | 1 | Current bit is the last bit of an error or overload delimiter |
| isTx | input | 1 | 1 = node is transmitter, 0 = receiver |
| msgStored | input | 1 | A message was written into a receive mailbox |
| autoOvlEn | input | 1 | Enables the automatic request overload |
| ovlStart | output | 1 | One-clock overload start request |
| ovlCause | output | 2 | 00 none, 01 intermission, 10 end-of-frame/delimiter, 11 automatic |

## Verification
The assertions assume three things about the inputs. Strobes never arrive on two clocks in a row. At most one position indication is active per strobe. `imIdx` is meaningful only while `imValid` is high. The stimulus drives each strobe for a single clock, separates strobes by idle clocks, and sweeps the position as one selector over none, intermission 0/1/2, last end-of-frame bit and last delimiter bit, so no two positions ever overlap. Role, bus level, enable and a preceding mailbox pulse are swept across every position. Each case ends with an intermission-start flush that shows whether a request is still pending.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_INTER = 2'b01,
    CAUSE_END   = 2'b10,
    CAUSE_AUTO  = 2'b11
  } cause_e;

  typedef struct packed {
    logic fireInter;
    logic fireEnd;
    logic fireAuto;
    logic setPend;
    logic clrPend;
  } ovl_strobe_t;
endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int IM_IDX_W      = 2,
  parameter int REACT_IM_BITS = 2
) (
  input  logic                bitValid,
  input  logic                rxBit,
  input  logic                imValid,
  input  logic [IM_IDX_W-1:0] imIdx,
  input  logic                eofLast,
  input  logic                delimLast,
  input  logic                isTx,
  input  logic                msgStored,
  input  logic                autoOvlEn,
  input  logic                pendQ,
  output ovl_strobe_t         strobes
);
  localparam logic [IM_IDX_W-1:0] REACT_LIMIT = IM_IDX_W'(REACT_IM_BITS);

  logic dominant;
  logic imReact;
  logic endReact;
  logic imStart;

  always_comb begin
    dominant = bitValid & ~rxBit;
    imReact  = dominant & imValid & (imIdx < REACT_LIMIT);
    // end-of-frame trigger is receiver-only; delimiter trigger is role-free
    endReact = dominant & ((eofLast & ~isTx) | delimLast);
    imStart  = bitValid & imValid & (imIdx == '0);

    strobes.fireInter = imReact;
    strobes.fireEnd   = endReact & ~imReact;
    strobes.fireAuto  = imStart & pendQ & autoOvlEn & ~imReact;
    strobes.setPend   = msgStored;
    strobes.clrPend   = imStart;
  end
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        autoOvlEn,
  input  ovl_strobe_t strobes,
  output logic        pendQ,
  output logic        startQ,
  output cause_e      causeQ
);
  cause_e causeNext;

  always_comb begin
    if (strobes.fireInter)      causeNext = CAUSE_INTER;
    else if (strobes.fireEnd)   causeNext = CAUSE_END;
    else if (strobes.fireAuto)  causeNext = CAUSE_AUTO;
    else                        causeNext = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= 1'b0;
      startQ <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else begin
      pendQ  <= autoOvlEn & (strobes.setPend | (pendQ & ~strobes.clrPend));
      startQ <= strobes.fireInter | strobes.fireEnd | strobes.fireAuto;
      causeQ <= causeNext;
    end
  end
endmodule

// File: rtl/ovl_trigger.sv
module ovl_trigger
  import ovl_pkg::*;
#(
  parameter int IM_IDX_W      = 2,
  parameter int REACT_IM_BITS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitValid,
  input  logic                rxBit,
  input  logic                imValid,
  input  logic [IM_IDX_W-1:0] imIdx,
  input  logic                eofLast,
  input  logic                delimLast,
  input  logic                isTx,
  input  logic                msgStored,
  input  logic                autoOvlEn,
  output logic                ovlStart,
  output logic [1:0]          ovlCause
);
  ovl_strobe_t strobes;
  logic        pendQ;
  cause_e      causeQ;

  ovl_ctrl #(.IM_IDX_W(IM_IDX_W), .REACT_IM_BITS(REACT_IM_BITS)) ctrlInst (
    .bitValid (bitValid),
    .rxBit    (rxBit),
    .imValid  (imValid),
    .imIdx    (imIdx),
    .eofLast  (eofLast),
    .delimLast(delimLast),
    .isTx     (isTx),
    .msgStored(msgStored),
    .autoOvlEn(autoOvlEn),
    .pendQ    (pendQ),
    .strobes  (strobes)
  );

  ovl_datapath dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .autoOvlEn(autoOvlEn),
    .strobes  (strobes),
    .pendQ    (pendQ),
    .startQ   (ovlStart),
    .causeQ   (causeQ)
  );

  assign ovlCause = causeQ;
endmodule

// File: rtl/ovl_trigger_chk.sv
module ovl_trigger_chk #(
  parameter int IM_IDX_W = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                bitValid,
  input logic                rxBit,
  input logic                imValid,
  input logic [IM_IDX_W-1:0] imIdx,
  input logic                eofLast,
  input logic                delimLast,
  input logic                isTx,
  input logic                autoOvlEn,
  input logic                ovlStart,
  input logic [1:0]          ovlCause
);
  // R2
  im_react_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !rxBit && imValid && imIdx < 2) |=> (ovlStart && ovlCause == 2'b01));

  // R3
  im_third_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && imValid && imIdx == 2 && !eofLast && !delimLast) |=> !ovlStart);

  // R4
  tx_eof_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && eofLast && isTx && !imValid && !delimLast) |=> !ovlStart);

  // R5
  delim_react_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !rxBit && delimLast && !imValid) |=> (ovlStart && ovlCause == 2'b10));

  // R6
  recessive_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && rxBit && !(imValid && imIdx == 0)) |=> !ovlStart);

  // R7
  auto_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovlStart && ovlCause == 2'b11) |-> $past(bitValid && imValid && imIdx == 0 && rxBit));

  // R9
  auto_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !autoOvlEn) |=> (ovlCause != 2'b11));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovlStart |=> !ovlStart);

  // R10
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ovlStart |-> (ovlCause == 2'b00));
endmodule

bind ovl_trigger ovl_trigger_chk #(.IM_IDX_W(IM_IDX_W)) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .bitValid (bitValid),
  .rxBit    (rxBit),
  .imValid  (imValid),
  .imIdx    (imIdx),
  .eofLast  (eofLast),
  .delimLast(delimLast),
  .isTx     (isTx),
  .autoOvlEn(autoOvlEn),
  .ovlStart (ovlStart),
  .ovlCause (ovlCause)
);

// File: tb/ovl_trigger_test.sv
module ovl_trigger_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitValid = 1'b0;
  logic       rxBit = 1'b1;
  logic       imValid = 1'b0;
  logic [1:0] imIdx = 2'd0;
  logic       eofLast = 1'b0;
  logic       delimLast = 1'b0;
  logic       isTx = 1'b0;
  logic       msgStored = 1'b0;
  logic       autoOvlEn = 1'b0;
  logic       ovlStart;
  logic [1:0] ovlCause;

  int checks = 0;
  int errors = 0;
  bit pendModel = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_trigger uut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .imValid(imValid), .imIdx(imIdx), .eofLast(eofLast), .delimLast(delimLast),
    .isTx(isTx), .msgStored(msgStored), .autoOvlEn(autoOvlEn),
    .ovlStart(ovlStart), .ovlCause(ovlCause)
  );

  task automatic check(input string req, input logic expStart, input logic [1:0] expCause);
    checks++;
    if (ovlStart !== expStart || ovlCause !== expCause) begin
      errors++;
      $display("FAIL %s: start=%b cause=%b expected start=%b cause=%b",
               req, ovlStart, ovlCause, expStart, expCause);
    end
  endtask

  // pos: 0 none, 1 im0, 2 im1, 3 im2, 4 last EOF, 5 last delimiter
  task automatic strobe(input int pos, input logic tx, input logic lvl);
    @(negedge clk);
    bitValid  = 1'b1;
    rxBit     = lvl;
    isTx      = tx;
    imValid   = (pos >= 1 && pos <= 3);
    imIdx     = (pos >= 1 && pos <= 3) ? 2'(pos - 1) : 2'd0;
    eofLast   = (pos == 4);
    delimLast = (pos == 5);
    @(negedge clk);
    bitValid = 1'b0; imValid = 1'b0; eofLast = 1'b0; delimLast = 1'b0; rxBit = 1'b1;
  endtask

  task automatic pulseMsg();
    @(negedge clk);
    msgStored = 1'b1;
    @(negedge clk);
    msgStored = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 1'b0, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 2'b00);
    // R1: nothing pending after reset
    autoOvlEn = 1'b1;
    strobe(1, 1'b0, 1'b1);
    check("R1", 1'b0, 2'b00);

    for (int en = 0; en < 2; en++) begin
      for (int pre = 0; pre < 2; pre++) begin
        for (int pos = 0; pos < 6; pos++) begin
          for (int tx = 0; tx < 2; tx++) begin
            for (int lvl = 0; lvl < 2; lvl++) begin
              bit dom, imr, endr, aut;
              logic [1:0] expC;
              string req;
              @(negedge clk);
              autoOvlEn = en[0];
              @(negedge clk);
              if (pre != 0) begin
                pulseMsg();
                pendModel = en[0];
                // R9: mailbox pulse alone never starts an overload
                check("R9", 1'b0, 2'b00);
              end
              dom  = (lvl == 0);
              imr  = dom && (pos == 1 || pos == 2);
              endr = dom && ((pos == 4 && tx == 0) || pos == 5);
              aut  = (pos == 1) && pendModel && en[0] && !imr;
              if (imr)       expC = 2'b01;
              else if (endr) expC = 2'b10;
              else if (aut)  expC = 2'b11;
              else           expC = 2'b00;
              if (imr && pendModel)      req = "R8";
              else if (imr)              req = "R2";
              else if (pos == 3)         req = "R3";
              else if (pos == 4)         req = "R4";
              else if (pos == 5 && dom)  req = "R5";
              else if (aut)              req = "R7";
              else if (pre != 0 && en == 0) req = "R9";
              else                       req = "R6";
              strobe(pos, tx[0], lvl[0]);
              check(req, expC != 2'b00, expC);
              if (pos == 1) pendModel = 1'b0;
              @(negedge clk);
              check("R10", 1'b0, 2'b00);
              // flush: recessive intermission start reveals a leftover request
              strobe(1, 1'b0, 1'b1);
              check("R7", pendModel && en[0], (pendModel && en[0]) ? 2'b11 : 2'b00);
              pendModel = 1'b0;
              @(negedge clk);
              check("R10", 1'b0, 2'b00);
            end
          end
        end
      end
    end

    // R9: dropping the enable discards a pending request
    @(negedge clk);
    autoOvlEn = 1'b1;
    pulseMsg();
    autoOvlEn = 1'b0;
    @(negedge clk);
    autoOvlEn = 1'b1;
    @(negedge clk);
    strobe(1, 1'b1, 1'b1);
    check("R9", 1'b0, 2'b00);

    // R7: request held across unrelated bits until intermission start
    pulseMsg();
    strobe(4, 1'b0, 1'b1);
    check("R7", 1'b0, 2'b00);
    strobe(3, 1'b0, 1'b1);
    check("R7", 1'b0, 2'b00);
    strobe(1, 1'b1, 1'b1);
    check("R7", 1'b1, 2'b11);
    @(negedge clk);
    check("R10", 1'b0, 2'b00);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule